// File: doc/BRIEF.md
# Partitioned Dadda 8x8 Unsigned Multiplier

This block multiplies two 8-bit unsigned operands and returns the full 16-bit product. It is purely combinational. The 64 AND-gate partial-product bits are split by column into two groups. The lower group holds columns 0 to 7 and the upper group holds columns 8 to 14. Both groups are compressed at the same time with Dadda-style full-adder and half-adder counters until two rows remain. Each group then has its own carry-propagate adder.

The two group results overlap in product bits 8 to 10 and are combined in three steps. The low byte is wired straight through from the lower group. A 3-bit ripple adder sums the overlap columns. The top five bits come from a carry-select style stage: it precomputes the upper group's bits plus one with a binary-to-excess-one converter and picks between that and the unchanged bits using the ripple carry. The block is meant to be dropped into a datapath wherever an unsigned byte multiply with a short critical path is needed.

Top module: `pdadda_mul8`

## Requirements
- R1: For every pair of unsigned 8-bit operands, `product` equals `opA * opB` as a 16-bit unsigned value, with no clock involved.
- R2: Partial-product bit `opA[j] & opB[i]` belongs to the lower group when i+j is 7 or less, and to the upper group (weight 2^8 taken out) when i+j is 8 or more; no bit is counted twice or dropped.
- R3: The lower group is reduced to two rows with 17 full-adder and 6 half-adder counters, and its adder gives an 11-bit value equal to the weighted sum of its partial-product bits.
- R4: The upper group is reduced to two rows with 14 full-adder and 5 half-adder counters, and its adder gives an 8-bit value equal to the weighted sum of its bits, relative to column 8.
- R5: `product[7:0]` equals bits 7..0 of the lower-group value.
- R6: `product[10:8]` equals the low three bits of lower-group bits 10..8 plus upper-group bits 2..0.
- R7: `product[15:11]` equals upper-group bits 7..3 when the carry out of the R6 sum is 0, and those bits plus one when that carry is 1.
- R8: A zero operand gives a zero product, and 255 x 255 gives 16'hFE01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | Unsigned multiplicand |
| opB | input | 8 | Unsigned multiplier |
| product | output | 16 | Unsigned product of opA and opB |

## Verification
The bench builds the block at its only configuration, 8-bit operands. At that size the whole operand space of 65536 pairs can be covered, so every pair is applied. For each pair, the bench computes its own lower-group and upper-group sums from the column split. It then checks the three product fields separately from the full product. This makes both outcomes of the overlap carry, and so both inputs of the top-bits select, show up many times.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int OP_W     = 8;
  localparam int PROD_W   = 2 * OP_W;
  localparam int LO_COLS  = OP_W;
  localparam int LO_BITS  = LO_COLS * (LO_COLS + 1) / 2;
  localparam int HI_BITS  = OP_W * OP_W - LO_BITS;
  localparam int LO_RES_W = 11;
  localparam int HI_RES_W = PROD_W - OP_W;
  localparam int LO_ROW_W = LO_RES_W - 1;
  localparam int HI_ROW_W = HI_RES_W - 1;
  localparam int OVL_W    = LO_RES_W - OP_W;
  localparam int TOP_W    = PROD_W - LO_RES_W;

  // flat position of lower-group bit (column col, row row)
  function automatic int loIdx(int col, int row);
    return col * (col + 1) / 2 + row;
  endfunction

  // flat position of upper-group bit (column col >= OP_W, row row)
  function automatic int hiIdx(int col, int row);
    int off;
    off = 0;
    for (int k = OP_W; k < col; k++) off += 2 * OP_W - 1 - k;
    return off + row;
  endfunction
endpackage

// File: rtl/pdm_cells.sv
module fa_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

module ha_cell (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

module rip_add #(
  parameter int W = 3
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;
  always_comb begin
    carry[0] = cin;
    for (int k = 0; k < W; k++) begin
      sum[k]       = x[k] ^ y[k] ^ carry[k];
      carry[k + 1] = (x[k] & y[k]) | (carry[k] & (x[k] ^ y[k]));
    end
    cout = carry[W];
  end
endmodule

module bec_inc #(
  parameter int W = 5
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] xPlusOne
);
  genvar k;
  assign xPlusOne[0] = ~x[0];
  generate
    for (k = 1; k < W; k++) begin : g_bit
      assign xPlusOne[k] = x[k] ^ (&x[k-1:0]);
    end
  endgenerate
endmodule

// File: rtl/pdm_lo_tree.sv
module pdm_lo_tree
  import pdm_pkg::*;
(
  input  logic [LO_BITS-1:0]  pp,
  output logic [LO_RES_W-1:0] loPart
);
  function automatic int at(int col, int row);
    return loIdx(col, row);
  endfunction

  logic [16:0] fS, fC;
  logic [5:0]  hS, hC;
  logic [LO_ROW_W-1:0] rowA, rowB;
  logic [LO_ROW_W-1:0] sumLo;
  logic                coutLo;

  // stage 1: limit height 6
  ha_cell u_h0 (.a(pp[at(6,0)]), .b(pp[at(6,1)]), .s(hS[0]), .co(hC[0]));
  fa_cell u_f0 (.a(pp[at(7,0)]), .b(pp[at(7,1)]), .ci(pp[at(7,2)]), .s(fS[0]), .co(fC[0]));
  ha_cell u_h1 (.a(pp[at(7,3)]), .b(pp[at(7,4)]), .s(hS[1]), .co(hC[1]));
  // stage 2: limit height 4
  ha_cell u_h2 (.a(pp[at(4,0)]), .b(pp[at(4,1)]), .s(hS[2]), .co(hC[2]));
  fa_cell u_f1 (.a(pp[at(5,0)]), .b(pp[at(5,1)]), .ci(pp[at(5,2)]), .s(fS[1]), .co(fC[1]));
  ha_cell u_h3 (.a(pp[at(5,3)]), .b(pp[at(5,4)]), .s(hS[3]), .co(hC[3]));
  fa_cell u_f2 (.a(pp[at(6,2)]), .b(pp[at(6,3)]), .ci(pp[at(6,4)]), .s(fS[2]), .co(fC[2]));
  fa_cell u_f3 (.a(pp[at(6,5)]), .b(pp[at(6,6)]), .ci(hS[0]), .s(fS[3]), .co(fC[3]));
  fa_cell u_f4 (.a(pp[at(7,5)]), .b(pp[at(7,6)]), .ci(pp[at(7,7)]), .s(fS[4]), .co(fC[4]));
  fa_cell u_f5 (.a(hC[0]), .b(fS[0]), .ci(hS[1]), .s(fS[5]), .co(fC[5]));
  // stage 3: limit height 3
  ha_cell u_h4 (.a(pp[at(3,0)]), .b(pp[at(3,1)]), .s(hS[4]), .co(hC[4]));
  fa_cell u_f6 (.a(pp[at(4,2)]), .b(pp[at(4,3)]), .ci(pp[at(4,4)]), .s(fS[6]), .co(fC[6]));
  fa_cell u_f7 (.a(pp[at(5,5)]), .b(hC[2]), .ci(fS[1]), .s(fS[7]), .co(fC[7]));
  fa_cell u_f8 (.a(fC[1]), .b(hC[3]), .ci(fS[2]), .s(fS[8]), .co(fC[8]));
  fa_cell u_f9 (.a(fC[2]), .b(fC[3]), .ci(fS[4]), .s(fS[9]), .co(fC[9]));
  fa_cell u_f10 (.a(fC[0]), .b(hC[1]), .ci(fC[4]), .s(fS[10]), .co(fC[10]));
  // stage 4: limit height 2
  ha_cell u_h5 (.a(pp[at(2,0)]), .b(pp[at(2,1)]), .s(hS[5]), .co(hC[5]));
  fa_cell u_f11 (.a(pp[at(3,2)]), .b(pp[at(3,3)]), .ci(hS[4]), .s(fS[11]), .co(fC[11]));
  fa_cell u_f12 (.a(hS[2]), .b(hC[4]), .ci(fS[6]), .s(fS[12]), .co(fC[12]));
  fa_cell u_f13 (.a(hS[3]), .b(fC[6]), .ci(fS[7]), .s(fS[13]), .co(fC[13]));
  fa_cell u_f14 (.a(fS[3]), .b(fC[7]), .ci(fS[8]), .s(fS[14]), .co(fC[14]));
  fa_cell u_f15 (.a(fS[5]), .b(fC[8]), .ci(fS[9]), .s(fS[15]), .co(fC[15]));
  fa_cell u_f16 (.a(fC[5]), .b(fC[9]), .ci(fS[10]), .s(fS[16]), .co(fC[16]));

  assign rowA = {fC[10], fC[15], fC[14], fC[13], fC[12], fC[11], hC[5],
                 pp[at(2,2)], pp[at(1,0)], pp[at(0,0)]};
  assign rowB = {fC[16], fS[16], fS[15], fS[14], fS[13], fS[12], fS[11],
                 hS[5], pp[at(1,1)], 1'b0};

  rip_add #(.W(LO_ROW_W)) u_cpa (
    .x(rowA), .y(rowB), .cin(1'b0), .sum(sumLo), .cout(coutLo)
  );
  assign loPart = {coutLo, sumLo};
endmodule

// File: rtl/pdm_hi_tree.sv
module pdm_hi_tree
  import pdm_pkg::*;
(
  input  logic [HI_BITS-1:0]  pp,
  output logic [HI_RES_W-1:0] hiPart
);
  function automatic int at(int col, int row);
    return hiIdx(col, row);
  endfunction

  logic [13:0] fS, fC;
  logic [4:0]  hS, hC;
  logic [HI_ROW_W-1:0] rowA, rowB;
  logic [HI_ROW_W-1:0] sumHi;
  logic                coutHi;

  // stage 1: limit height 6
  ha_cell u_h0 (.a(pp[at(8,0)]), .b(pp[at(8,1)]), .s(hS[0]), .co(hC[0]));
  ha_cell u_h1 (.a(pp[at(9,0)]), .b(pp[at(9,1)]), .s(hS[1]), .co(hC[1]));
  // stage 2: limit height 4
  fa_cell u_f0 (.a(pp[at(8,2)]), .b(pp[at(8,3)]), .ci(pp[at(8,4)]), .s(fS[0]), .co(fC[0]));
  fa_cell u_f1 (.a(pp[at(9,2)]), .b(pp[at(9,3)]), .ci(pp[at(9,4)]), .s(fS[1]), .co(fC[1]));
  ha_cell u_h2 (.a(pp[at(9,5)]), .b(hC[0]), .s(hS[2]), .co(hC[2]));
  fa_cell u_f2 (.a(pp[at(10,0)]), .b(pp[at(10,1)]), .ci(pp[at(10,2)]), .s(fS[2]), .co(fC[2]));
  fa_cell u_f3 (.a(pp[at(10,3)]), .b(pp[at(10,4)]), .ci(hC[1]), .s(fS[3]), .co(fC[3]));
  fa_cell u_f4 (.a(pp[at(11,0)]), .b(pp[at(11,1)]), .ci(pp[at(11,2)]), .s(fS[4]), .co(fC[4]));
  // stage 3: limit height 3
  ha_cell u_h3 (.a(pp[at(8,5)]), .b(pp[at(8,6)]), .s(hS[3]), .co(hC[3]));
  fa_cell u_f5 (.a(hS[1]), .b(fC[0]), .ci(fS[1]), .s(fS[5]), .co(fC[5]));
  fa_cell u_f6 (.a(fC[1]), .b(hC[2]), .ci(fS[2]), .s(fS[6]), .co(fC[6]));
  fa_cell u_f7 (.a(pp[at(11,3)]), .b(fC[2]), .ci(fC[3]), .s(fS[7]), .co(fC[7]));
  fa_cell u_f8 (.a(pp[at(12,0)]), .b(pp[at(12,1)]), .ci(pp[at(12,2)]), .s(fS[8]), .co(fC[8]));
  // stage 4: limit height 2
  ha_cell u_h4 (.a(hS[0]), .b(fS[0]), .s(hS[4]), .co(hC[4]));
  fa_cell u_f9 (.a(hS[2]), .b(hC[3]), .ci(fS[5]), .s(fS[9]), .co(fC[9]));
  fa_cell u_f10 (.a(fS[3]), .b(fC[5]), .ci(fS[6]), .s(fS[10]), .co(fC[10]));
  fa_cell u_f11 (.a(fS[4]), .b(fC[6]), .ci(fS[7]), .s(fS[11]), .co(fC[11]));
  fa_cell u_f12 (.a(fC[4]), .b(fC[7]), .ci(fS[8]), .s(fS[12]), .co(fC[12]));
  fa_cell u_f13 (.a(pp[at(13,0)]), .b(pp[at(13,1)]), .ci(fC[8]), .s(fS[13]), .co(fC[13]));

  assign rowA = {pp[at(14,0)], fC[12], fC[11], fC[10], fC[9], hC[4], hS[3]};
  assign rowB = {fC[13], fS[13], fS[12], fS[11], fS[10], fS[9], hS[4]};

  rip_add #(.W(HI_ROW_W)) u_cpa (
    .x(rowA), .y(rowB), .cin(1'b0), .sum(sumHi), .cout(coutHi)
  );
  assign hiPart = {coutHi, sumHi};
endmodule

// File: rtl/pdm_merge.sv
module pdm_merge
  import pdm_pkg::*;
(
  input  logic [LO_RES_W-1:0] loPart,
  input  logic [HI_RES_W-1:0] hiPart,
  output logic [PROD_W-1:0]   product
);
  logic [OVL_W-1:0] ovlSum;
  logic             ovlCarry;
  logic [TOP_W-1:0] topPlain, topInc;

  rip_add #(.W(OVL_W)) u_ovl (
    .x(loPart[LO_RES_W-1:OP_W]), .y(hiPart[OVL_W-1:0]), .cin(1'b0),
    .sum(ovlSum), .cout(ovlCarry)
  );

  assign topPlain = hiPart[HI_RES_W-1:OVL_W];
  bec_inc #(.W(TOP_W)) u_bec (.x(topPlain), .xPlusOne(topInc));

  assign product = {ovlCarry ? topInc : topPlain, ovlSum, loPart[OP_W-1:0]};
endmodule

// File: rtl/pdadda_mul8.sv
module pdadda_mul8
  import pdm_pkg::*;
(
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] product
);
  logic [LO_BITS-1:0]  loPp;
  logic [HI_BITS-1:0]  hiPp;
  logic [LO_RES_W-1:0] loPart;
  logic [HI_RES_W-1:0] hiPart;

  genvar i, j;
  generate
    for (i = 0; i < OP_W; i++) begin : g_row
      for (j = 0; j < OP_W; j++) begin : g_col
        if (i + j < LO_COLS) begin : g_lo
          assign loPp[loIdx(i + j, i)] = opA[j] & opB[i];
        end else begin : g_hi
          assign hiPp[hiIdx(i + j, OP_W - 1 - j)] = opA[j] & opB[i];
        end
      end
    end
  endgenerate

  pdm_lo_tree u_lo (.pp(loPp), .loPart(loPart));
  pdm_hi_tree u_hi (.pp(hiPp), .hiPart(hiPart));
  pdm_merge   u_mrg (.loPart(loPart), .hiPart(hiPart), .product(product));
endmodule

// File: rtl/pdadda_mul8_chk.sv
module pdadda_mul8_chk (
  input logic [7:0]  opA,
  input logic [7:0]  opB,
  input logic [15:0] product,
  input logic [10:0] loPart,
  input logic [7:0]  hiPart
);
  function automatic int groupSum(logic [7:0] a, logic [7:0] b, bit upper);
    int s;
    s = 0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (a[c] && b[r]) begin
          if (!upper && (r + c) <= 7) s += 1 << (r + c);
          if (upper && (r + c) >= 8) s += 1 << (r + c - 8);
        end
    return s;
  endfunction

  always_comb begin
    if (!$isunknown({opA, opB})) begin
      // R1
      a_r1_exact_product: assert (product == 16'(opA) * 16'(opB));
      // R3
      a_r3_lo_group_value: assert (int'(loPart) == groupSum(opA, opB, 1'b0));
      // R4
      a_r4_hi_group_value: assert (int'(hiPart) == groupSum(opA, opB, 1'b1));
      // R5
      a_r5_low_byte_pass: assert (product[7:0] == loPart[7:0]);
      // R6
      a_r6_overlap_sum: assert (product[10:8] == 3'(loPart[10:8] + hiPart[2:0]));
      // R7
      a_r7_top_select: assert (product[15:11] ==
        5'(hiPart[7:3] + 5'((4'(loPart[10:8]) + 4'(hiPart[2:0])) >> 3)));
    end
  end
endmodule

bind pdadda_mul8 pdadda_mul8_chk u_chk (
  .opA(opA), .opB(opB), .product(product), .loPart(loPart), .hiPart(hiPart)
);

// File: tb/pdadda_mul8_bench.sv
module pdadda_mul8_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [15:0] product;

  int testsRun   = 0;
  int testsFail  = 0;
  bit done       = 1'b0;
  bit sawCarry0  = 1'b0;
  bit sawCarry1  = 1'b0;
  int expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pdadda_mul8 u_pdadda_mul8 (.opA(opA), .opB(opB), .product(product));

  task automatic check(bit ok, string req, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s: a=%0d b=%0d actual=%0d expected=%0d", req, opA, opB, act, exp);
    end
  endtask

  // behavioural split sums (R2 column rule)
  function automatic int split(int a, int b, bit upper);
    int s;
    s = 0;
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++)
        if (((a >> c) & 1) && ((b >> r) & 1)) begin
          if (!upper && r + c < 8)  s += 1 << (r + c);
          if (upper  && r + c >= 8) s += 1 << (r + c - 8);
        end
    return s;
  endfunction

  task automatic apply(int a, int b);
    @(posedge clk);
    opA <= 8'(a);
    opB <= 8'(b);
    expQ.push_back(a * b);
    expQ.push_back(split(a, b, 1'b0));
    expQ.push_back(split(a, b, 1'b1));
    @(negedge clk);
    begin
      int full, lo, hi, ovl, carry, top;
      full  = expQ.pop_front();
      lo    = expQ.pop_front();
      hi    = expQ.pop_front();
      ovl   = (lo >> 8) + (hi & 7);
      carry = ovl >> 3;
      top   = ((hi >> 3) + carry) & 31;
      if (carry != 0) sawCarry1 = 1'b1; else sawCarry0 = 1'b1;
      check(int'(product) == full, "R1 full product", int'(product), full);
      check(int'(product[7:0]) == (lo & 255), "R5/R3 low byte from lower group",
            int'(product[7:0]), lo & 255);
      check(int'(product[10:8]) == (ovl & 7), "R6/R2 overlap ripple sum",
            int'(product[10:8]), ovl & 7);
      check(int'(product[15:11]) == top, "R7/R4 top bits select",
            int'(product[15:11]), top);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    // R8 corners first
    apply(0, 0);
    check(product == 16'h0000, "R8 zero times zero", int'(product), 0);
    apply(0, 255);
    check(product == 16'h0000, "R8 zero operand", int'(product), 0);
    apply(255, 255);
    check(product == 16'hFE01, "R8 max operands", int'(product), 16'hFE01);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(a, b);
    check(sawCarry0 && sawCarry1, "R7 both select inputs exercised",
          int'({sawCarry1, sawCarry0}), 3);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end
endmodule